// File: doc/BRIEF.md
# Self-stepping FSM state register with LFSR successor

This block holds the state word of a finite state machine. Besides loading the next-state word computed by the surrounding logic, it can produce a next state on its own: the state bits are wired as a linear feedback shift register, so the register can step to the LFSR successor of its present code without any help from the next-state logic. A one-bit select, driven by the FSM logic each cycle, picks between the two. Any transition whose target code is the LFSR successor of its source code then needs no next-state logic at all; that logic can treat those entries as don't-care and only has to drive the select low.

The same shift-register wiring serves as an on-chip pattern generator. When test-enable is high, the register free-runs through its fixed code sequence, whatever the select and the next-state bus say. A synchronous reset loads a fixed nonzero code and overrides everything else. The feedback polynomial is a parameter vector whose bit j is the coefficient of x^j. The constant term and the top term must both be 1, and any other value is refused when the design elaborates. A second parameter picks the standard (external XOR) or the modular (internal XOR) wiring. The successor code is also driven out combinationally, so a checker can compare it with a model every cycle.

Top module: `smart_state_reg`

## Requirements
- R1: When rst is high at a rising clock edge, state_q holds RESET_CODE after that edge (default 1), whatever test_en, mode_load and next_state are.
- R2: When rst is low, test_en is low and mode_load is 1, state_q captures next_state at the edge.
- R3: When rst is low, test_en is low and mode_load is 0, state_q takes the value succ_code had before the edge. next_state has no effect.
- R4: When rst is low and test_en is high, state_q takes the value succ_code had before the edge, whatever mode_load and next_state are.
- R5: In standard form (FORM=0), with state bit i read as register cell q_i: succ_code[i] = state_q[i+1] for i < W-1, and succ_code[W-1] = XOR over j < W of (POLY[j] AND state_q[j]).
- R6: With W=2 and POLY=3'b111 (1+x+x^2), succ_code maps 0 to 0, 3 to 1, 1 to 2 and 2 to 3.
- R7: The all-zero code is its own successor, so a register loaded with zero stays at zero while it steps autonomously.
- R8: In modular form (FORM=1): succ_code[0] = state_q[W-1], and succ_code[i] = state_q[i-1] XOR (POLY[i] AND state_q[W-1]) for 0 < i < W.
- R9: A standard-form register built with the reciprocal polynomial runs the sequence backwards, up to a reversal of bit order: for every code y, its successor of bitrev(succ(y)) equals bitrev(y).
- R10: With the default primitive polynomial 1+x+x^4 (W=4), 15 autonomous steps from RESET_CODE visit every nonzero code exactly once and return to RESET_CODE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to RESET_CODE |
| test_en | input | 1 | Free-run as pattern generator; overrides mode_load |
| mode_load | input | 1 | 1: load next_state; 0: step to LFSR successor |
| next_state | input | W | Next-state word from the FSM logic |
| state_q | output | W | Registered present state |
| succ_code | output | W | Combinational LFSR successor of state_q |

## Verification
Three controls can act on the same edge: the logic-driven select asking for a load, test-enable demanding a free-running step, and reset. The bench drives test_en and mode_load high together, with a next_state value that differs from the successor, and expects the successor to win. It also raises rst alongside both and expects RESET_CODE. Random stimulus mixes all three at independent rates, and a bench model applies the stated priority to judge every cycle.

// File: rtl/smart_sr_pkg.sv
package smart_sr_pkg;
  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_TEST  = 2'd1,
    OP_LOAD  = 2'd2,
    OP_STEP  = 2'd3
  } sr_op_e;

  localparam int FORM_STANDARD = 0;
  localparam int FORM_MODULAR  = 1;
endpackage

// File: rtl/sr_op_decode.sv
module sr_op_decode
  import smart_sr_pkg::*;
(
  input  logic   rst,
  input  logic   test_en,
  input  logic   mode_load,
  output sr_op_e op
);
  // reset beats test-enable, which beats the logic-driven select
  always_comb begin
    if (rst)            op = OP_RESET;
    else if (test_en)   op = OP_TEST;
    else if (mode_load) op = OP_LOAD;
    else                op = OP_STEP;
  end
endmodule

// File: rtl/sr_lfsr_next.sv
module sr_lfsr_next
  import smart_sr_pkg::*;
#(
  parameter int           W    = 4,
  parameter logic [W:0]   POLY = 5'b10011,
  parameter int           FORM = FORM_STANDARD
) (
  input  logic [W-1:0] cur,
  output logic [W-1:0] nxt
);
  localparam int TOP = W - 1;

  if (FORM == FORM_STANDARD) begin : g_standard
    logic fb;
    always_comb begin
      fb = 1'b0;
      for (int j = 0; j < W; j++) fb = fb ^ (POLY[j] & cur[j]);
    end
    assign nxt[TOP-1:0] = cur[TOP:1];
    assign nxt[TOP]     = fb;
  end else begin : g_modular
    assign nxt[0] = cur[TOP];
    for (genvar i = 1; i < W; i++) begin : g_tap
      assign nxt[i] = cur[i-1] ^ (POLY[i] & cur[TOP]);
    end
  end
endmodule

// File: rtl/sr_state_bank.sv
module sr_state_bank
  import smart_sr_pkg::*;
#(
  parameter int         W          = 4,
  parameter logic [W-1:0] RESET_CODE = {{(W-1){1'b0}}, 1'b1}
) (
  input  logic         clk,
  input  sr_op_e       op,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] step_val,
  output logic [W-1:0] state_q
);
  always_ff @(posedge clk) begin
    unique case (op)
      OP_RESET: state_q <= RESET_CODE;
      OP_LOAD:  state_q <= load_val;
      OP_TEST,
      OP_STEP:  state_q <= step_val;
      default:  state_q <= RESET_CODE;
    endcase
  end
endmodule

// File: rtl/smart_state_reg.sv
module smart_state_reg
  import smart_sr_pkg::*;
#(
  parameter int           W          = 4,
  parameter logic [W:0]   POLY       = 5'b10011,
  parameter int           FORM       = FORM_STANDARD,
  parameter logic [W-1:0] RESET_CODE = {{(W-1){1'b0}}, 1'b1}
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         test_en,
  input  logic         mode_load,
  input  logic [W-1:0] next_state,
  output logic [W-1:0] state_q,
  output logic [W-1:0] succ_code
);
  localparam bit POLY_OK = (POLY[0] == 1'b1) && (POLY[W] == 1'b1);

  if (!POLY_OK || W < 2) begin : g_bad_param
    $error("smart_state_reg: POLY needs g0 = gW = 1 and W >= 2");
  end

  sr_op_e op;

  sr_op_decode u_decode (
    .rst       (rst),
    .test_en   (test_en),
    .mode_load (mode_load),
    .op        (op)
  );

  sr_lfsr_next #(.W(W), .POLY(POLY), .FORM(FORM)) u_next (
    .cur (state_q),
    .nxt (succ_code)
  );

  sr_state_bank #(.W(W), .RESET_CODE(RESET_CODE)) u_bank (
    .clk      (clk),
    .op       (op),
    .load_val (next_state),
    .step_val (succ_code),
    .state_q  (state_q)
  );
endmodule

// File: rtl/smart_state_reg_chk.sv
module smart_state_reg_chk #(
  parameter int           W          = 4,
  parameter logic [W-1:0] RESET_CODE = {{(W-1){1'b0}}, 1'b1}
) (
  input logic         clk,
  input logic         rst,
  input logic         test_en,
  input logic         mode_load,
  input logic [W-1:0] next_state,
  input logic [W-1:0] state_q,
  input logic [W-1:0] succ_code
);
  a_r1_reset_code: assert property (@(posedge clk)
    rst |=> state_q == RESET_CODE);

  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    (!test_en && mode_load) |=> state_q == $past(next_state));

  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    (!test_en && !mode_load) |=> state_q == $past(succ_code));

  a_r4_test_priority: assert property (@(posedge clk) disable iff (rst)
    test_en |=> state_q == $past(succ_code));

  a_r7_zero_fixed: assert property (@(posedge clk) disable iff (rst)
    (state_q == '0) |-> succ_code == '0);

  a_r10_nonzero_kept: assert property (@(posedge clk) disable iff (rst)
    (state_q != '0 && (test_en || !mode_load)) |=> state_q != '0);
endmodule

bind smart_state_reg smart_state_reg_chk #(.W(W), .RESET_CODE(RESET_CODE)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .test_en    (test_en),
  .mode_load  (mode_load),
  .next_state (next_state),
  .state_q    (state_q),
  .succ_code  (succ_code)
);

// File: tb/smart_state_reg_bench.sv
module smart_state_reg_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] P_MAIN  = 5'b10011; // 1+x+x^4
  localparam logic [4:0] P_RECIP = 5'b11001; // 1+x^3+x^4

  logic       clk = 1'b0;
  logic       rst = 1'b1, test_en = 1'b0, mode_load = 1'b0;
  logic [3:0] next_state = '0;
  logic [3:0] st_main, sc_main, st_mod, sc_mod, st_rec, sc_rec;
  logic [1:0] st_sm, sc_sm;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [3:0] m_state;

  always #(CLK_PERIOD/2) clk = ~clk;

  smart_state_reg u_smart_state_reg (.clk(clk), .rst(rst), .test_en(test_en),
    .mode_load(mode_load), .next_state(next_state), .state_q(st_main), .succ_code(sc_main));
  smart_state_reg #(.W(4), .POLY(P_MAIN), .FORM(1)) u_modular (.clk(clk), .rst(rst),
    .test_en(test_en), .mode_load(mode_load), .next_state(next_state),
    .state_q(st_mod), .succ_code(sc_mod));
  smart_state_reg #(.W(4), .POLY(P_RECIP)) u_recip (.clk(clk), .rst(rst),
    .test_en(test_en), .mode_load(mode_load), .next_state(next_state),
    .state_q(st_rec), .succ_code(sc_rec));
  smart_state_reg #(.W(2), .POLY(3'b111)) u_small (.clk(clk), .rst(rst),
    .test_en(test_en), .mode_load(mode_load), .next_state(next_state[1:0]),
    .state_q(st_sm), .succ_code(sc_sm));

  function automatic logic [3:0] ref_std(logic [4:0] p, logic [3:0] x);
    logic [3:0] r;
    r[2:0] = x[3:1];
    r[3]   = ^(p[3:0] & x);
    return r;
  endfunction

  function automatic logic [3:0] ref_mod(logic [4:0] p, logic [3:0] x);
    logic [3:0] r;
    r[0] = x[3];
    for (int i = 1; i < 4; i++) r[i] = x[i-1] ^ (p[i] & x[3]);
    return r;
  endfunction

  function automatic logic [3:0] rev4(logic [3:0] x);
    return {x[0], x[1], x[2], x[3]};
  endfunction

  function automatic logic [1:0] ref_small(logic [1:0] x);
    case (x)
      2'd0: return 2'd0;
      2'd3: return 2'd1;
      2'd1: return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a falling edge; drives, lets one rising edge pass, returns at next falling edge
  task automatic cycle(logic r, logic te, logic md, logic [3:0] nx);
    rst = r; test_en = te; mode_load = md; next_state = nx;
    if (r)        m_state = 4'd1;
    else if (te)  m_state = ref_std(P_MAIN, m_state);
    else if (md)  m_state = nx;
    else          m_state = ref_std(P_MAIN, m_state);
    @(posedge clk);
    #(CLK_PERIOD/2);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [15:0] seen;
    logic [3:0] s;
    void'($urandom(32'h5eed));
    m_state = '0;
    @(negedge clk);
    cycle(1, 1, 1, 4'hA);
    // R1 reset with every other control asserted
    check("R1 reset main", st_main, 8'd1);
    check("R1 reset small", st_sm, 8'd1);

    // R6 two-bit map, R2 loads
    for (int c = 0; c < 4; c++) begin
      cycle(0, 0, 1, 4'(c));
      check("R2 load small", st_sm, 8'(c));
      check("R6 small successor", sc_sm, 8'(ref_small(2'(c))));
    end

    // R5, R8 successor maps and R9 reciprocal reversal, all 16 codes
    for (int c = 0; c < 16; c++) begin
      cycle(0, 0, 1, 4'(c));
      check("R2 load main", st_main, 8'(c));
      check("R5 standard successor", sc_main, 8'(ref_std(P_MAIN, 4'(c))));
      check("R8 modular successor", sc_mod, 8'(ref_mod(P_MAIN, 4'(c))));
      s = sc_main;
      cycle(0, 0, 1, rev4(s));
      check("R9 reciprocal reversal", sc_rec, 8'(rev4(4'(c))));
    end

    // R7 zero stays zero while stepping, with next_state noise ignored
    cycle(0, 0, 1, 4'd0);
    cycle(0, 0, 0, 4'hF);
    check("R7 zero fixed point", st_main, 8'd0);
    cycle(0, 1, 1, 4'h9);
    check("R7 zero under test", st_main, 8'd0);

    // R10 full period from reset code
    cycle(1, 0, 0, 4'd0);
    seen = '0;
    for (int k = 0; k < 15; k++) begin
      cycle(0, 0, 0, 4'(k));
      check("R3 step ignores next_state", st_main, 8'(m_state));
      if (st_main == 4'd0 || seen[st_main]) check("R10 unique nonzero", 8'(st_main), 8'hFF);
      seen[st_main] = 1'b1;
    end
    check("R10 back to reset code", st_main, 8'd1);
    check("R10 all nonzero visited", 8'(seen[15:8]) & 8'(seen[7:0] | 8'h01), 8'hFF & 8'(seen[15:8]));
    check("R10 coverage count", 8'($countones(seen[15:1])), 8'd15);

    // collisions: test-enable against load, reset against both
    cycle(0, 0, 1, 4'h6);
    cycle(0, 1, 1, 4'h6);
    check("R4 test beats load", st_main, 8'(ref_std(P_MAIN, 4'h6)));
    cycle(0, 1, 0, 4'hC);
    check("R4 test with select low", st_main, 8'(m_state));
    cycle(1, 1, 1, 4'hE);
    check("R1 reset beats test and load", st_main, 8'd1);

    // random mix
    for (int n = 0; n < 800; n++) begin
      logic r, te, md;
      logic [3:0] nx;
      string tag;
      r  = ($urandom % 24) == 0;
      te = ($urandom % 4) == 0;
      md = $urandom % 2;
      nx = 4'($urandom);
      tag = r ? "R1 random" : te ? "R4 random" : md ? "R2 random" : "R3 random";
      cycle(r, te, md, nx);
      check(tag, st_main, 8'(m_state));
    end

    finish_run();
  end
endmodule